// File: doc/BRIEF.md
# Interleaved Page Layout Remapper

This block sits between a flash page buffer and a 64-bit word stream. It translates between two arrangements of one page. In the interleaved arrangement that the flash controller uses, each chunk holds its data words, then its free spare words, then its ECC words, and the next chunk follows. In the user arrangement, every data word of the page comes first, then every spare word, then every ECC word. Within each region the chunks keep their order. For each word it accepts, the block emits a write strobe, the remapped buffer address and the word itself.

All lengths are counted in 64-bit words, because every transfer is a multiple of eight bytes. A 30-byte ECC field is therefore configured as four words. Every chunk except the last uses the regular data, spare and ECC lengths. The last chunk has its own three lengths, and any of them may be zero. A raw spare mode walks only the spare and ECC sections, chunk by chunk. It places them after the data region, so that out-of-band bytes can be read without reordering. The factory bad-block marker sits at physical word address equal to the total data length. When the word at that flash address passes through, the block reports the user-side address the word maps to, and whether it falls inside a data section.

The configuration must stay stable while the block is busy. A transfer begins with a one-cycle start pulse and ends with a done pulse.

Top module: `page_layout_remap`

## Requirements
- R1: After reset, busy, done, inReady, outWe, markHit and markInData are all 0.
- R2: With cfgToFlash=0 and cfgRawOob=0, words arrive in interleaved order (per chunk: data, spare, ECC). Data word o of chunk c is written to address c*D+o. Spare word o is written to totData+c*S+o. ECC word o is written to totData+totSpare+c*E+o. Here D, S and E are the regular lengths and totX=(N-1)*X+lastX.
- R3: With cfgToFlash=1 and cfgRawOob=0, words arrive in user order (all data sections chunk by chunk, then all spare, then all ECC). Each word is written to its interleaved address c*(D+S+E) plus its offset inside the chunk.
- R4: Chunk N-1 uses the last-chunk lengths. A section of length 0 consumes no input word. inReady is 1 only while busy and the current section is non-empty.
- R5: With cfgRawOob=1, only the spare and ECC sections are walked, in interleaved order. The k-th accepted word is written to totData+k, whatever cfgToFlash is.
- R6: markHit pulses together with the outWe of the word whose interleaved address equals totData. markAddr then holds that word's user-side address, and markInData is 1 when the word lies in a data section.
- R7: cfgErr is 1 when cfgChunks is 0, when totData+totSpare+totEcc differs from cfgPageWords, or when either data length exceeds MAX_DATA_WORDS (256 words, 2 KiB). While cfgErr is 1, start is ignored.
- R8: A word accepted at a clock edge (inValid and inReady) appears on outWord with outWe one cycle later. done pulses for one cycle with the write of the final word (or after the final empty section), and busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgChunks | input | CHUNK_W | Number of chunks N, last one included |
| cfgDataLen | input | LEN_W | Regular data section length in words |
| cfgSpareLen | input | LEN_W | Regular spare section length in words |
| cfgEccLen | input | LEN_W | Regular ECC section length in words |
| cfgLastData | input | LEN_W | Data length of the last chunk |
| cfgLastSpare | input | LEN_W | Spare length of the last chunk |
| cfgLastEcc | input | LEN_W | ECC length of the last chunk |
| cfgPageWords | input | ADDR_W | Expected page size in words |
| cfgToFlash | input | 1 | 1: user order in, interleaved addresses out |
| cfgRawOob | input | 1 | 1: spare and ECC sections only |
| start | input | 1 | Begin a page transfer |
| inValid | input | 1 | Input word valid |
| inWord | input | DATA_W | Input word |
| inReady | output | 1 | Block accepts a word this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| cfgErr | output | 1 | Configuration inconsistent |
| outWe | output | 1 | Page buffer write strobe |
| outAddr | output | ADDR_W | Page buffer word address |
| outWord | output | DATA_W | Page buffer write word |
| markHit | output | 1 | Bad-block marker word passed |
| markAddr | output | ADDR_W | User-side address of the marker word |
| markInData | output | 1 | Marker word lies in a data section |

## Verification
A wrong section or chunk position shows up on outAddr at the very next write strobe, because each address is derived directly from the walker's position. A walker that mishandles a zero-length section or the last chunk's lengths shows up as a missing, extra or shifted write, or as a done pulse that comes early or late. A wrong total appears at once on cfgErr, before any start. A marker comparison against the wrong address shows up as markHit on the wrong write, or as no markHit at all.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    SEC_DATA  = 2'd0,
    SEC_SPARE = 2'd1,
    SEC_ECC   = 2'd2
  } sec_e;

  typedef struct packed {
    logic kick;
    logic fire;
  } strobe_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int CHUNK_W = 4,
  parameter int LEN_W   = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    cfgErr,
  input  logic                    cfgToFlash,
  input  logic                    cfgRawOob,
  input  logic [CHUNK_W-1:0]      cfgChunks,
  input  logic [2:0][LEN_W-1:0]   regLen,
  input  logic [2:0][LEN_W-1:0]   lastLen,
  input  logic                    inValid,
  output logic                    inReady,
  output logic                    busy,
  output logic                    done,
  output sec_e                    curSec,
  output logic [CHUNK_W-1:0]      curChunk,
  output logic [LEN_W-1:0]        curOff,
  output logic                    isLast,
  output logic                    userOrder,
  output logic                    rawMode,
  output strobe_t                 strb
);
  logic               busyQ, doneQ, userQ, rawQ;
  logic [CHUNK_W-1:0] chunkQ;
  sec_e               secQ;
  logic [LEN_W-1:0]   offQ;
  logic [LEN_W-1:0]   curLen;
  logic               lastChunk, fire, endOfSec, finalSec, kick;
  sec_e               secAfter;

  always_comb begin
    lastChunk = (chunkQ == cfgChunks - CHUNK_W'(1));
    unique case (secQ)
      SEC_DATA:  curLen = lastChunk ? lastLen[0] : regLen[0];
      SEC_SPARE: curLen = lastChunk ? lastLen[1] : regLen[1];
      default:   curLen = lastChunk ? lastLen[2] : regLen[2];
    endcase
    unique case (secQ)
      SEC_DATA:  secAfter = SEC_SPARE;
      default:   secAfter = SEC_ECC;
    endcase
    inReady  = busyQ && (curLen != '0);
    fire     = inReady && inValid;
    endOfSec = busyQ && ((curLen == '0) || (fire && offQ == curLen - LEN_W'(1)));
    finalSec = lastChunk && (secQ == SEC_ECC);
    kick     = !busyQ && start && !cfgErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      userQ  <= 1'b0;
      rawQ   <= 1'b0;
      chunkQ <= '0;
      secQ   <= SEC_DATA;
      offQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (kick) begin
        busyQ  <= 1'b1;
        chunkQ <= '0;
        offQ   <= '0;
        rawQ   <= cfgRawOob;
        userQ  <= cfgToFlash && !cfgRawOob;
        secQ   <= cfgRawOob ? SEC_SPARE : SEC_DATA;
      end else if (endOfSec) begin
        offQ <= '0;
        if (finalSec) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else if (userQ) begin
          if (lastChunk) begin
            chunkQ <= '0;
            secQ   <= secAfter;
          end else begin
            chunkQ <= chunkQ + CHUNK_W'(1);
          end
        end else if (secQ == SEC_ECC) begin
          chunkQ <= chunkQ + CHUNK_W'(1);
          secQ   <= rawQ ? SEC_SPARE : SEC_DATA;
        end else begin
          secQ <= secAfter;
        end
      end else if (fire) begin
        offQ <= offQ + LEN_W'(1);
      end
    end
  end

  assign busy      = busyQ;
  assign done      = doneQ;
  assign curSec    = secQ;
  assign curChunk  = chunkQ;
  assign curOff    = offQ;
  assign isLast    = lastChunk;
  assign userOrder = userQ;
  assign rawMode   = rawQ;
  assign strb.kick = kick;
  assign strb.fire = fire;
endmodule

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int ADDR_W         = 12,
  parameter int CHUNK_W        = 4,
  parameter int LEN_W          = 9,
  parameter int MAX_DATA_WORDS = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  sec_e                  curSec,
  input  logic [CHUNK_W-1:0]    curChunk,
  input  logic [LEN_W-1:0]      curOff,
  input  logic                  isLast,
  input  logic                  userOrder,
  input  logic                  rawMode,
  input  logic [CHUNK_W-1:0]    cfgChunks,
  input  logic [2:0][LEN_W-1:0] regLen,
  input  logic [2:0][LEN_W-1:0] lastLen,
  input  logic [ADDR_W-1:0]     cfgPageWords,
  input  logic [DATA_W-1:0]     inWord,
  output logic                  cfgErr,
  output logic                  outWe,
  output logic [ADDR_W-1:0]     outAddr,
  output logic [DATA_W-1:0]     outWord,
  output logic                  markHit,
  output logic [ADDR_W-1:0]     markAddr,
  output logic                  markInData
);
  localparam int SUM_W = LEN_W + CHUNK_W + 2;
  localparam int MAXV  = MAX_DATA_WORDS;

  logic [CHUNK_W-1:0]    lastIdx;
  logic [2:0][SUM_W-1:0] secTot;
  logic [SUM_W-1:0]      pageTot, span, chunkBase;
  logic [SUM_W-1:0]      secOff, regionBase, regSel, flashAddr, userAddr, dest;
  logic [SUM_W-1:0]      rawCnt;
  logic [2:0][LEN_W-1:0] useLen;
  logic                  oversize, hitNow;

  assign lastIdx = cfgChunks - CHUNK_W'(1);

  for (genvar g = 0; g < 3; g++) begin : g_sec
    assign secTot[g] = SUM_W'(lastIdx) * SUM_W'(regLen[g]) + SUM_W'(lastLen[g]);
    assign useLen[g] = isLast ? lastLen[g] : regLen[g];
  end

  always_comb begin
    pageTot  = secTot[0] + secTot[1] + secTot[2];
    span     = SUM_W'(regLen[0]) + SUM_W'(regLen[1]) + SUM_W'(regLen[2]);
    oversize = (SUM_W'(regLen[0]) > SUM_W'(MAXV)) || (SUM_W'(lastLen[0]) > SUM_W'(MAXV));
    cfgErr   = (cfgChunks == '0) || (pageTot != SUM_W'(cfgPageWords)) || oversize;

    unique case (curSec)
      SEC_DATA: begin
        secOff     = '0;
        regionBase = '0;
        regSel     = SUM_W'(regLen[0]);
      end
      SEC_SPARE: begin
        secOff     = SUM_W'(useLen[0]);
        regionBase = secTot[0];
        regSel     = SUM_W'(regLen[1]);
      end
      default: begin
        secOff     = SUM_W'(useLen[0]) + SUM_W'(useLen[1]);
        regionBase = secTot[0] + secTot[1];
        regSel     = SUM_W'(regLen[2]);
      end
    endcase

    chunkBase = SUM_W'(curChunk) * span;
    flashAddr = chunkBase + secOff + SUM_W'(curOff);
    userAddr  = regionBase + SUM_W'(curChunk) * regSel + SUM_W'(curOff);
    if (rawMode)        dest = secTot[0] + rawCnt;
    else if (userOrder) dest = flashAddr;
    else                dest = userAddr;
    hitNow = strb.fire && (flashAddr == secTot[0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawCnt     <= '0;
      outWe      <= 1'b0;
      outAddr    <= '0;
      outWord    <= '0;
      markHit    <= 1'b0;
      markAddr   <= '0;
      markInData <= 1'b0;
    end else begin
      if (strb.kick)                rawCnt <= '0;
      else if (strb.fire && rawMode) rawCnt <= rawCnt + SUM_W'(1);
      outWe      <= strb.fire;
      markHit    <= hitNow;
      markInData <= hitNow && (curSec == SEC_DATA);
      if (strb.fire) begin
        outAddr <= dest[ADDR_W-1:0];
        outWord <= inWord;
      end
      if (hitNow) markAddr <= userAddr[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/page_layout_remap.sv
module page_layout_remap
  import remap_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int ADDR_W         = 12,
  parameter int CHUNK_W        = 4,
  parameter int LEN_W          = 9,
  parameter int MAX_DATA_WORDS = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CHUNK_W-1:0] cfgChunks,
  input  logic [LEN_W-1:0]   cfgDataLen,
  input  logic [LEN_W-1:0]   cfgSpareLen,
  input  logic [LEN_W-1:0]   cfgEccLen,
  input  logic [LEN_W-1:0]   cfgLastData,
  input  logic [LEN_W-1:0]   cfgLastSpare,
  input  logic [LEN_W-1:0]   cfgLastEcc,
  input  logic [ADDR_W-1:0]  cfgPageWords,
  input  logic               cfgToFlash,
  input  logic               cfgRawOob,
  input  logic               start,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inWord,
  output logic               inReady,
  output logic               busy,
  output logic               done,
  output logic               cfgErr,
  output logic               outWe,
  output logic [ADDR_W-1:0]  outAddr,
  output logic [DATA_W-1:0]  outWord,
  output logic               markHit,
  output logic [ADDR_W-1:0]  markAddr,
  output logic               markInData
);
  logic [2:0][LEN_W-1:0] regLen, lastLen;
  strobe_t               strb;
  sec_e                  curSec;
  logic [CHUNK_W-1:0]    curChunk;
  logic [LEN_W-1:0]      curOff;
  logic                  isLast, userOrder, rawMode;

  assign regLen  = {cfgEccLen, cfgSpareLen, cfgDataLen};
  assign lastLen = {cfgLastEcc, cfgLastSpare, cfgLastData};

  remap_ctrl #(.CHUNK_W(CHUNK_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgErr(cfgErr),
    .cfgToFlash(cfgToFlash), .cfgRawOob(cfgRawOob), .cfgChunks(cfgChunks),
    .regLen(regLen), .lastLen(lastLen), .inValid(inValid),
    .inReady(inReady), .busy(busy), .done(done),
    .curSec(curSec), .curChunk(curChunk), .curOff(curOff), .isLast(isLast),
    .userOrder(userOrder), .rawMode(rawMode), .strb(strb)
  );

  remap_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .LEN_W(LEN_W),
             .MAX_DATA_WORDS(MAX_DATA_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curSec(curSec), .curChunk(curChunk),
    .curOff(curOff), .isLast(isLast), .userOrder(userOrder), .rawMode(rawMode),
    .cfgChunks(cfgChunks), .regLen(regLen), .lastLen(lastLen),
    .cfgPageWords(cfgPageWords), .inWord(inWord), .cfgErr(cfgErr),
    .outWe(outWe), .outAddr(outAddr), .outWord(outWord),
    .markHit(markHit), .markAddr(markAddr), .markInData(markInData)
  );
endmodule

// File: rtl/page_layout_remap_chk.sv
module page_layout_remap_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              inValid,
  input logic [DATA_W-1:0] inWord,
  input logic              inReady,
  input logic              busy,
  input logic              done,
  input logic              cfgErr,
  input logic              outWe,
  input logic [ADDR_W-1:0] outAddr,
  input logic [DATA_W-1:0] outWord,
  input logic              markHit,
  input logic              markInData,
  input logic [ADDR_W-1:0] cfgPageWords
);
  p_we_follows_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> $past(inValid && inReady));

  p_word_passthru_r8: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> (outWord == $past(inWord)));

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  p_ready_when_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  p_err_blocks_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && cfgErr) |=> !busy);

  p_mark_with_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    markHit |-> outWe);

  p_mark_data_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    markInData |-> markHit);

  p_addr_in_page_r2: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> (outAddr < cfgPageWords));
endmodule

bind page_layout_remap page_layout_remap_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inWord(inWord),
  .inReady(inReady), .busy(busy), .done(done), .cfgErr(cfgErr), .outWe(outWe),
  .outAddr(outAddr), .outWord(outWord), .markHit(markHit), .markInData(markInData),
  .cfgPageWords(cfgPageWords)
);

// File: tb/test_page_layout_remap.sv
module test_page_layout_remap;
  localparam int DATA_W = 64, ADDR_W = 12, CHUNK_W = 4, LEN_W = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CHUNK_W-1:0] cfgChunks = '0;
  logic [LEN_W-1:0] cfgDataLen = '0, cfgSpareLen = '0, cfgEccLen = '0;
  logic [LEN_W-1:0] cfgLastData = '0, cfgLastSpare = '0, cfgLastEcc = '0;
  logic [ADDR_W-1:0] cfgPageWords = '0;
  logic cfgToFlash = 1'b0, cfgRawOob = 1'b0, start = 1'b0, inValid = 1'b0;
  logic [DATA_W-1:0] inWord = '0;
  logic inReady, busy, done, cfgErr, outWe, markHit, markInData;
  logic [ADDR_W-1:0] outAddr, markAddr;
  logic [DATA_W-1:0] outWord;

  page_layout_remap i_page_layout_remap (
    .clk(clk), .rstN(rstN), .cfgChunks(cfgChunks), .cfgDataLen(cfgDataLen),
    .cfgSpareLen(cfgSpareLen), .cfgEccLen(cfgEccLen), .cfgLastData(cfgLastData),
    .cfgLastSpare(cfgLastSpare), .cfgLastEcc(cfgLastEcc), .cfgPageWords(cfgPageWords),
    .cfgToFlash(cfgToFlash), .cfgRawOob(cfgRawOob), .start(start),
    .inValid(inValid), .inWord(inWord), .inReady(inReady), .busy(busy),
    .done(done), .cfgErr(cfgErr), .outWe(outWe), .outAddr(outAddr),
    .outWord(outWord), .markHit(markHit), .markAddr(markAddr), .markInData(markInData)
  );

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  int gN, gRaw, gToFlash, totD, totS, totE, span, nExp;
  int gR[3], gL[3], base[3];
  int expAddr[512], expMarkAddr[512];
  bit expMark[512], expMarkData[512];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int secLen(int c, int s);
    return (c == gN - 1) ? gL[s] : gR[s];
  endfunction

  function automatic int secOff(int c, int s);
    int v = 0;
    for (int i = 0; i < s; i++) v += secLen(c, i);
    return v;
  endfunction

  task automatic addExp(int c, int s, int o);
    int flash = c * span + secOff(c, s) + o;
    int user  = base[s] + c * gR[s] + o;
    expAddr[nExp]     = gRaw ? totD + nExp : (gToFlash ? flash : user);
    expMark[nExp]     = (flash == totD);
    expMarkAddr[nExp] = user;
    expMarkData[nExp] = (s == 0);
    nExp++;
  endtask

  task automatic setCfg(int n, int rd, int rs, int re, int ld, int ls, int le,
                        int page, bit toFlash, bit raw);
    cfgChunks = CHUNK_W'(n);
    cfgDataLen = LEN_W'(rd); cfgSpareLen = LEN_W'(rs); cfgEccLen = LEN_W'(re);
    cfgLastData = LEN_W'(ld); cfgLastSpare = LEN_W'(ls); cfgLastEcc = LEN_W'(le);
    cfgPageWords = ADDR_W'(page); cfgToFlash = toFlash; cfgRawOob = raw;
  endtask

  task automatic runCase(input string req, input int caseId, int n, int rd, int rs, int re,
                         int ld, int ls, int le, bit toFlash, bit raw, bit gaps);
    int r = 0, sent = 0;
    bit doneSeen = 0;
    gN = n; gR = '{rd, rs, re}; gL = '{ld, ls, le};
    gRaw = raw; gToFlash = toFlash;
    totD = (n - 1) * rd + ld; totS = (n - 1) * rs + ls; totE = (n - 1) * re + le;
    span = rd + rs + re;
    base = '{0, totD, totD + totS};
    nExp = 0;
    if (raw || !toFlash) begin
      for (int c = 0; c < n; c++)
        for (int s = (raw ? 1 : 0); s < 3; s++)
          for (int o = 0; o < secLen(c, s); o++) addExp(c, s, o);
    end else begin
      for (int s = 0; s < 3; s++)
        for (int c = 0; c < n; c++)
          for (int o = 0; o < secLen(c, s); o++) addExp(c, s, o);
    end
    setCfg(n, rd, rs, re, ld, ls, le, totD + totS + totE, toFlash, raw);
    @(negedge clk);
    chk(cfgErr == 1'b0, "R7", "cfgErr on consistent config", cfgErr, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 2000 && !doneSeen; cyc++) begin
      if (outWe) begin
        if (r < nExp) begin
          chk(outAddr == ADDR_W'(expAddr[r]), req, $sformatf("case %0d addr of word %0d", caseId, r),
              outAddr, expAddr[r]);
          chk(outWord == {16'hC0DE, 16'(caseId), 32'(r)}, "R8", "word passthrough",
              outWord, {16'hC0DE, 16'(caseId), 32'(r)});
          chk(markHit == expMark[r], "R6", $sformatf("case %0d markHit at word %0d", caseId, r),
              markHit, expMark[r]);
          if (expMark[r]) begin
            chk(markAddr == ADDR_W'(expMarkAddr[r]), "R6", "markAddr", markAddr, expMarkAddr[r]);
            chk(markInData == expMarkData[r], "R6", "markInData", markInData, expMarkData[r]);
          end
        end else begin
          chk(1'b0, req, "extra write", r, nExp);
        end
        r++;
      end
      if (done) begin
        doneSeen = 1;
        chk(r == nExp, "R8", $sformatf("case %0d writes at done", caseId), r, nExp);
        chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
      end
      if (!doneSeen && inReady && sent < nExp && !(gaps && (cyc % 4 == 3))) begin
        inValid = 1'b1;
        inWord  = {16'hC0DE, 16'(caseId), 32'(sent)};
        sent++;
      end else begin
        inValid = 1'b0;
      end
      if (!doneSeen) @(negedge clk);
    end
    inValid = 1'b0;
    chk(doneSeen, "R8", $sformatf("case %0d done seen", caseId), doneSeen, 1);
    @(negedge clk);
  endtask

  task automatic errCase(input int caseId, int n, int rd, int rs, int re,
                         int ld, int ls, int le, int page);
    setCfg(n, rd, rs, re, ld, ls, le, page, 1'b0, 1'b0);
    @(negedge clk);
    chk(cfgErr == 1'b1, "R7", $sformatf("case %0d cfgErr", caseId), cfgErr, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R7", "start ignored busy", busy, 0);
    chk(inReady == 1'b0, "R7", "start ignored inReady", inReady, 0);
    @(negedge clk);
    chk(outWe == 1'b0, "R7", "no write after ignored start", outWe, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && inReady == 0, "R1", "idle flags in reset", {busy, done, inReady}, 0);
    chk(outWe == 0 && markHit == 0 && markInData == 0, "R1", "write/mark in reset",
        {outWe, markHit, markInData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && outWe == 0, "R1", "idle after reset release", {busy, outWe}, 0);

    // two equal chunks: marker lands in data of chunk 1
    runCase("R2", 1, 2, 4, 1, 2, 4, 1, 2, 1'b0, 1'b0, 1'b0);
    runCase("R3", 2, 2, 4, 1, 2, 4, 1, 2, 1'b1, 1'b0, 1'b1);
    runCase("R5", 3, 2, 4, 1, 2, 4, 1, 2, 1'b0, 1'b1, 1'b0);
    // three chunks, last chunk without spare (R4)
    runCase("R4", 4, 3, 3, 1, 2, 2, 0, 3, 1'b0, 1'b0, 1'b1);
    runCase("R4", 5, 3, 3, 1, 2, 2, 0, 3, 1'b1, 1'b0, 1'b0);
    runCase("R5", 6, 3, 3, 1, 2, 2, 0, 3, 1'b1, 1'b1, 1'b1);
    // single chunk: marker in spare, not in data
    runCase("R6", 7, 1, 0, 0, 0, 5, 2, 1, 1'b0, 1'b0, 1'b0);
    runCase("R3", 8, 1, 0, 0, 0, 5, 2, 1, 1'b1, 1'b0, 1'b0);
    // final ECC section absent: done after empty section
    runCase("R4", 9, 2, 3, 1, 1, 2, 1, 0, 1'b0, 1'b0, 1'b1);
    runCase("R4", 10, 2, 3, 1, 1, 2, 1, 0, 1'b1, 1'b0, 1'b0);
    // four chunks, larger sections
    runCase("R2", 11, 4, 6, 2, 4, 3, 1, 2, 1'b0, 1'b0, 1'b1);
    runCase("R3", 12, 4, 6, 2, 4, 3, 1, 2, 1'b1, 1'b0, 1'b1);

    errCase(20, 2, 4, 1, 2, 4, 1, 2, 15);
    errCase(21, 0, 0, 0, 0, 0, 0, 0, 0);
    errCase(22, 2, 257, 0, 0, 1, 0, 0, 258);
    finishRun();
  end
endmodule